// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Latch Loader

This block holds the compare values for a bank of seven timer compare channels. Each channel has two storage stages. The first is a compare register that software writes. The second is a shadow latch, and the latch is the value that the compare logic downstream actually uses. Software can therefore prepare a new compare value at any time. The value only reaches the comparator when a chosen load event occurs, which avoids glitches in a waveform in the middle of a period.

Each channel has a 2-bit load-event field, and it selects when the register moves into the latch:
- `00`: on the write itself.
- `01`: when the counter is at zero.
- `10`: when the counter is at zero, or at channel 0's latch value in up/down mode.
- `11`: when the counter equals the latch value.

A global 2-bit grouping field can bind channels into groups. A group updates on one clock edge under the load field of its leader channel, so several duty-cycle values change together. The free-running counter is outside the block. The block only observes the counter value and the counter mode.

Top module: `cmp_latch_bank`

## Requirements
- R1: While reset is asserted, every compare register and every latch is zero.
- R2: Load field `00`: the latch takes the written data on the same clock edge that writes the register.
- R3: Load field `01`: the latch loads on an edge where the counter value is zero and the counter is running.
- R4: Load field `10`: the latch loads when the counter is zero in up mode (`01`) or continuous mode (`10`). In up/down mode (`11`), it loads when the counter is zero or equals channel 0's latch.
- R5: Load field `11`: the latch loads when the counter equals the leader channel's current latch value.
- R6: With counter mode `00` (stopped), fields `01`, `10` and `11` cause no load. A register written in that state leaves its latch unchanged.
- R7: Grouping `00`: every channel follows its own load field.
- R8: Grouping `01`: channels 1+2, 3+4 and 5+6 form pairs led by the lower channel of each pair. Channel 0 stays alone.
- R9: Grouping `10`: channels 1–3 are led by channel 1 and channels 4–6 by channel 4. Channel 0 stays alone.
- R10: Grouping `11`: all seven channels are led by channel 1.
- R11: All members of a group load on the same edge. Each member takes the value its register holds after that edge, so a write that coincides with a load event passes straight into the latch.
- R12: When the leader's field is `00`, a write to any member of the group loads every member of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | DW | Current counter value |
| mode_i | input | 2 | Counter mode: 00 stopped, 01 up, 10 continuous, 11 up/down |
| grp_i | input | 2 | Grouping selection (R7–R10) |
| ld_sel_i | input | 14 | Load-event field per channel; channel n uses bits [2n+1:2n] |
| wr_en_i | input | 7 | Register write strobe per channel |
| wr_data_i | input | DW | Write data shared by all channels |
| latch_o | output | 7*DW | Latch values; channel n on bits [n*DW +: DW] |

## Verification
A register write and a load event can fall on the same edge. In that case the latch must capture the freshly written data rather than the old register contents. This collision is forced directly:
- channel 3 is written while the counter sits at zero in up mode;
- a companion case writes while the counter is stopped, to confirm that no load occurs.

The sweeps run the counter through a small range of values together with write data from the same range. Zero hits, latch matches and writes therefore coincide often. After each edge, every latch is compared with a model that applies the write before the load.

// File: rtl/cl_pkg.sv
package cl_pkg;

  // Channel count is fixed by the grouping patterns, which name channels 0..6.
  localparam int NCH = 7;
  localparam int CHW = $clog2(NCH);

  typedef enum logic [1:0] {
    LD_ON_WRITE    = 2'b00,
    LD_AT_ZERO     = 2'b01,
    LD_ZERO_OR_TOP = 2'b10,
    LD_AT_MATCH    = 2'b11
  } ld_evt_e;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    GRP_NONE   = 2'b00,
    GRP_PAIR   = 2'b01,
    GRP_TRIPLE = 2'b10,
    GRP_ALL    = 2'b11
  } grp_e;

  // Leader channel index for channel ch under grouping g.
  function automatic logic [CHW-1:0] leader_of(input logic [1:0] g, input int unsigned ch);
    logic [CHW-1:0] res;
    case (g)
      GRP_NONE:   res = CHW'(ch);
      GRP_PAIR:   res = (ch == 0) ? '0 : CHW'(ch - (1 - (ch % 2)));
      GRP_TRIPLE: res = (ch == 0) ? '0 : ((ch <= 3) ? CHW'(1) : CHW'(4));
      default:    res = CHW'(1);
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cl_group_map.sv
module cl_group_map
  import cl_pkg::*;
(
  input  logic [1:0]                grp_i,
  output logic [NCH-1:0][CHW-1:0]   lead_idx_o,
  output logic [NCH-1:0][NCH-1:0]   member_o
);

  // member_o[j][i] is set when channel i follows leader j.
  for (genvar i = 0; i < NCH; i++) begin : g_lead
    assign lead_idx_o[i] = leader_of(grp_i, i);
  end

  always_comb begin
    member_o = '0;
    for (int j = 0; j < NCH; j++) begin
      for (int i = 0; i < NCH; i++) begin
        member_o[j][i] = (lead_idx_o[i] == CHW'(j));
      end
    end
  end

endmodule

// File: rtl/cl_load_event.sv
module cl_load_event
  import cl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    field_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] own_latch_i,
  input  logic [DW-1:0] base_latch_i,
  input  logic          grp_wr_i,
  output logic          fire_o
);

  logic running;
  logic at_zero;
  logic at_own;
  logic at_base;

  always_comb begin
    running = (mode_i != MODE_STOP);
    at_zero = (cnt_i == '0);
    at_own  = (cnt_i == own_latch_i);
    at_base = (mode_i == MODE_UPDN) && (cnt_i == base_latch_i);
    case (field_i)
      LD_ON_WRITE:    fire_o = grp_wr_i;
      LD_AT_ZERO:     fire_o = running && at_zero;
      LD_ZERO_OR_TOP: fire_o = running && (at_zero || at_base);
      default:        fire_o = running && at_own;
    endcase
  end

endmodule

// File: rtl/cl_channel.sv
module cl_channel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  output logic [DW-1:0] latch_o
);

  logic [DW-1:0] reg_q, reg_d;
  logic [DW-1:0] lat_q, lat_d;

  // The latch takes the register value as it stands after this edge.
  always_comb begin
    reg_d = wr_en_i ? wr_data_i : reg_q;
    lat_d = reg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en_i) begin
      reg_q <= reg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (load_i) begin
      lat_q <= lat_d;
    end
  end

  assign latch_o = lat_q;

endmodule

// File: rtl/cmp_latch_bank.sv
module cmp_latch_bank
  import cl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     cnt_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        grp_i,
  input  logic [2*NCH-1:0]  ld_sel_i,
  input  logic [NCH-1:0]    wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [NCH*DW-1:0] latch_o
);

  logic [NCH-1:0][CHW-1:0] lead_idx;
  logic [NCH-1:0][NCH-1:0] member;
  logic [NCH-1:0][DW-1:0]  lat;
  logic [NCH-1:0]          grp_wr;
  logic [NCH-1:0]          fire_lead;
  logic [NCH-1:0]          ld_fire;

  cl_group_map u_map (
    .grp_i      (grp_i),
    .lead_idx_o (lead_idx),
    .member_o   (member)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_evt
    assign grp_wr[j] = |(wr_en_i & member[j]);

    cl_load_event #(.DW(DW)) u_evt (
      .field_i      (ld_sel_i[2*j +: 2]),
      .mode_i       (mode_i),
      .cnt_i        (cnt_i),
      .own_latch_i  (lat[j]),
      .base_latch_i (lat[0]),
      .grp_wr_i     (grp_wr[j]),
      .fire_o       (fire_lead[j])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ld_fire[i] = fire_lead[lead_idx[i]];

    cl_channel #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i[i]),
      .wr_data_i (wr_data_i),
      .load_i    (ld_fire[i]),
      .latch_o   (lat[i])
    );

    assign latch_o[i*DW +: DW] = lat[i];
  end

endmodule

// File: rtl/cl_checker.sv
module cl_checker
  import cl_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     cnt_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        grp_i,
  input logic [2*NCH-1:0]  ld_sel_i,
  input logic [NCH-1:0]    wr_en_i,
  input logic [DW-1:0]     wr_data_i,
  input logic [NCH*DW-1:0] latch_o,
  input logic [NCH-1:0]    ld_fire
);

  for (genvar i = 0; i < NCH; i++) begin : g_chan_props
    // R2
    a_r2_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_i == 2'b00 && ld_sel_i[2*i +: 2] == 2'b00 && wr_en_i[i])
      |=> latch_o[i*DW +: DW] == $past(wr_data_i));
    // R3
    a_r3_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_i == 2'b00 && ld_sel_i[2*i +: 2] == 2'b01 && mode_i != 2'b00 && cnt_i == '0)
      |-> ld_fire[i]);
  end

  // R6
  a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && wr_en_i == '0) |=> $stable(latch_o));

  // R8
  a_r8_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_i == 2'b01) |-> (ld_fire[1] == ld_fire[2] && ld_fire[3] == ld_fire[4]
                          && ld_fire[5] == ld_fire[6]));

  // R9
  a_r9_triples: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_i == 2'b10) |-> ((ld_fire[3:1] == 3'b000 || ld_fire[3:1] == 3'b111)
                          && (ld_fire[6:4] == 3'b000 || ld_fire[6:4] == 3'b111)));

  // R10
  a_r10_all: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_i == 2'b11) |-> (ld_fire == '0 || (&ld_fire)));

endmodule

bind cmp_latch_bank cl_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .mode_i    (mode_i),
  .grp_i     (grp_i),
  .ld_sel_i  (ld_sel_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .latch_o   (latch_o),
  .ld_fire   (ld_fire)
);

// File: tb/cmp_latch_bank_tb.sv
module cmp_latch_bank_tb;

  localparam int DW = 16;
  localparam int N  = 7;

  logic            clk;
  logic            rst_n;
  logic [DW-1:0]   cnt;
  logic [1:0]      mode;
  logic [1:0]      grp;
  logic [2*N-1:0]  ld_sel;
  logic [N-1:0]    wr_en;
  logic [DW-1:0]   wr_data;
  logic [N*DW-1:0] lat_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [DW-1:0] mreg [N];
  logic [DW-1:0] mlat [N];
  logic [31:0]   seed = 32'h1234_5678;

  cmp_latch_bank #(.DW(DW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt),
    .mode_i    (mode),
    .grp_i     (grp),
    .ld_sel_i  (ld_sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .latch_o   (lat_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk) cycles++;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Leader channel per the grouping requirements R7..R10.
  function automatic int lead(input int g, input int i);
    case (g)
      0: return i;
      1: return (i == 0) ? 0 : ((i % 2 == 1) ? i : i - 1);
      2: return (i == 0) ? 0 : ((i <= 3) ? 1 : 4);
      default: return 1;
    endcase
  endfunction

  function automatic string gtag(input int g);
    case (g)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string ftag(input int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input logic [1:0] md, input logic [1:0] g, input logic [2*N-1:0] fl,
                      input logic [N-1:0] we, input logic [DW-1:0] wd,
                      input logic [DW-1:0] cv, input string tag_ovr);
    bit fire [N];
    logic [DW-1:0] nreg [N];
    mode = md; grp = g; ld_sel = fl; wr_en = we; wr_data = wd; cnt = cv;
    for (int j = 0; j < N; j++) begin
      int f;
      bit run;
      bit anywr;
      f = int'(fl[2*j +: 2]);
      run = (md != 2'b00);
      anywr = 0;
      for (int k = 0; k < N; k++) if (we[k] && lead(int'(g), k) == j) anywr = 1;
      case (f)
        0: fire[j] = anywr;
        1: fire[j] = run && (cv == 0);
        2: fire[j] = run && ((cv == 0) || (md == 2'b11 && cv == mlat[0]));
        default: fire[j] = run && (cv == mlat[j]);
      endcase
    end
    for (int i = 0; i < N; i++) nreg[i] = we[i] ? wd : mreg[i];
    for (int i = 0; i < N; i++) begin
      mreg[i] = nreg[i];
      if (fire[lead(int'(g), i)]) mlat[i] = nreg[i];
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      string t;
      logic [DW-1:0] got;
      got = lat_o[i*DW +: DW];
      if (tag_ovr != "") t = tag_ovr;
      else t = {gtag(int'(g)), "/", ftag(int'(fl[2*lead(int'(g), i) +: 2]))};
      checks++;
      if (got !== mlat[i]) begin
        fails++;
        $display("FAIL %s ch%0d actual %0d expected %0d", t, i, got, mlat[i]);
      end
    end
  endtask

  initial begin : watchdog
    wait (cycles > 100000 || done);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d (actual hang, expected completion)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; cnt = '0; mode = 2'b00; grp = 2'b00; ld_sel = '0; wr_en = '0; wr_data = '0;
    for (int i = 0; i < N; i++) begin mreg[i] = '0; mlat[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      checks++;
      if (lat_o[i*DW +: DW] !== '0) begin
        fails++;
        $display("FAIL R1 ch%0d actual %0d expected 0", i, lat_o[i*DW +: DW]);
      end
    end
    rst_n = 1;
    @(negedge clk);

    // R6: write while stopped, field 01 everywhere, counter at zero: no load
    step(2'b00, 2'b00, {N{2'b01}}, 7'b0001000, 16'd9, 16'd0, "R6");
    // R11: write coinciding with a zero event passes the new data straight through
    step(2'b01, 2'b00, {N{2'b01}}, 7'b0001000, 16'd5, 16'd0, "R11");
    // R12: pair 1+2 led by channel 1 with field 00; writing only channel 2 loads both
    step(2'b01, 2'b01, 14'b00_00_00_00_11_00_00, 7'b0000010, 16'd4, 16'd3, "R12");
    step(2'b01, 2'b01, 14'b00_00_00_00_11_00_00, 7'b0000100, 16'd6, 16'd3, "R12");
    // R4: up/down mode load at channel 0 latch value
    step(2'b11, 2'b00, {N{2'b01}}, 7'b0000001, 16'd3, 16'd1, "R4");
    step(2'b11, 2'b00, {N{2'b10}}, 7'b1111110, 16'd2, 16'd7, "R4");
    step(2'b11, 2'b00, {N{2'b10}}, 7'b0000000, 16'd0, 16'd0, "R4");
    step(2'b11, 2'b00, {N{2'b01}}, 7'b0000001, 16'd6, 16'd0, "R4");
    step(2'b11, 2'b00, {N{2'b10}}, 7'b1111110, 16'd1, 16'd6, "R4");

    // Sweep: every grouping, uniform and mixed load fields, pseudo-random traffic
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < 5; p++) begin
        logic [2*N-1:0] fl;
        for (int i = 0; i < N; i++)
          fl[2*i +: 2] = (p < 4) ? 2'(p) : 2'((i * 3 + g) % 4);
        for (int c = 0; c < 400; c++) begin
          logic [31:0] r;
          logic [N-1:0] we;
          r = rnd();
          for (int i = 0; i < N; i++) we[i] = (r[2*i +: 2] == 2'b00);
          step(r[15:14], 2'(g), fl, we, 16'(r[18:16]), 16'(r[21:19]), "");
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule